// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and main memory. Each store leaves the processor at once and waits here until memory takes it. Storage is a small ring of slots, and each slot covers one 32-byte line of eight 32-bit words. A per-word mask records which words are filled. When a new store falls in the same line as a waiting slot that is not yet being written out, the store lands in that slot and no new slot is used. Stores that target the uncached I/O window never combine: each one gets its own slot and its own memory write.

Slots leave in the order they were allocated, through a request/acknowledge port that carries a line address, a full line of data and per-byte enables. Only the filled words are enabled. The oldest slot counts as in flight from the moment it reaches the head of the ring, so it is frozen. A cache read miss presents its address to the block. The block holds the read back while any slot still covers that line, so the read only reaches memory after the newer data has been written there.

Top module: `coalescing_store_buffer`

## Requirements
- R1: After reset the buffer is empty: `mem_req` is 0, `st_ready` is 1 and `rd_ready` is 1.
- R2: An accepted store to byte address A, word index w = A[4:2], is written out with `mem_addr` = A with bits [4:0] cleared, its data at `mem_data[w*32 +: 32]` and `mem_be[w*4 +: 4]` = 4'hF.
- R3: A store whose line matches a waiting slot that is neither the head slot nor an I/O slot is merged into that slot. The line leaves in a single write that carries the union of the words.
- R4: The head slot, which is presented on the memory port whenever the buffer is not empty, accepts no merges. A store to its line takes a new slot, which is written out after it.
- R5: A store whose address satisfies A[31:28] = 4'hF is an I/O store. It never merges and never receives merges. Each such store is written out alone, with exactly one word enabled.
- R6: Slots are written to memory oldest first, in order of allocation.
- R7: `st_ready` is 0 only when all slots are occupied and the presented store matches no mergeable slot. A merging store is accepted even when the buffer is full.
- R8: While `rd_valid` is 1, `rd_ready` is 0 if any waiting slot, including the head, covers the line of `rd_addr`. It becomes 1 once those slots have been written out.
- R9: `mem_addr`, `mem_data` and `mem_be` hold steady while `mem_req` is 1 and `mem_ack` is 0. Each cycle with both high retires exactly one slot.
- R10: A later store to a word already in a waiting slot replaces that word, so the newest value is written out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store presented |
| st_addr | input | 32 | Store byte address (word aligned) |
| st_data | input | 32 | Store data word |
| st_ready | output | 1 | Store accepted this cycle when high |
| rd_valid | input | 1 | Read miss presented |
| rd_addr | input | 32 | Read miss byte address |
| rd_ready | output | 1 | Read may go to memory |
| mem_req | output | 1 | Line write request |
| mem_addr | output | 32 | Line-aligned write address |
| mem_data | output | 256 | Line write data |
| mem_be | output | 32 | Byte enables for the line |
| mem_ack | input | 1 | Memory accepts the request |

## Verification
A wrong merge target or a bad word mask shows up on the memory port as wrong enables or wrong words. It appears on the very write that retires the slot, and that write can come many cycles after the store that caused it. An out-of-order ring pointer appears as a line address arriving in the wrong order on the next acknowledge. A stale line comparison shows at once as `rd_ready` holding a read that should go, or releasing one that should wait. A miscounted occupancy shows as `st_ready` dropping too early or a slot being overwritten, which is seen when the lost line never appears.

// File: rtl/coalescing_store_buffer.sv
module coalescing_store_buffer #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 8,
  parameter int ENTRIES = 4,
  parameter logic [ADDR_W-1:0] IO_MASK = 32'hF000_0000,
  parameter logic [ADDR_W-1:0] IO_BASE = 32'hF000_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          st_valid,
  input  logic [ADDR_W-1:0]             st_addr,
  input  logic [WORD_W-1:0]             st_data,
  output logic                          st_ready,
  input  logic                          rd_valid,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic                          rd_ready,
  output logic                          mem_req,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic [WORD_W*WORDS-1:0]       mem_data,
  output logic [WORD_W*WORDS/8-1:0]     mem_be,
  input  logic                          mem_ack
);
  localparam int BYTES_W = WORD_W / 8;
  localparam int LINE_W  = WORD_W * WORDS;
  localparam int BE_W    = LINE_W / 8;
  localparam int OFF_W   = $clog2(BE_W);
  localparam int WB_W    = $clog2(BYTES_W);
  localparam int WIX_W   = $clog2(WORDS);
  localparam int BLK_W   = ADDR_W - OFF_W;
  localparam int PTR_W   = $clog2(ENTRIES);
  localparam int CNT_W   = PTR_W + 1;

  logic              vld_q  [ENTRIES];
  logic              io_q   [ENTRIES];
  logic [BLK_W-1:0]  blk_q  [ENTRIES];
  logic [WORDS-1:0]  mask_q [ENTRIES];
  logic [LINE_W-1:0] data_q [ENTRIES];
  logic [PTR_W-1:0]  head_q, tail_q;
  logic [CNT_W-1:0]  cnt_q;

  wire [BLK_W-1:0] st_blk  = st_addr[ADDR_W-1:OFF_W];
  wire [BLK_W-1:0] rd_blk  = rd_addr[ADDR_W-1:OFF_W];
  wire [WIX_W-1:0] st_widx = st_addr[WB_W +: WIX_W];
  wire             st_io   = (st_addr & IO_MASK) == IO_BASE;
  wire             full    = cnt_q == CNT_W'(ENTRIES);

  logic             mrg_hit, rd_hit;
  logic [PTR_W-1:0] mrg_idx;

  always_comb begin
    mrg_hit = 1'b0;
    mrg_idx = '0;
    rd_hit  = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (vld_q[i] && !io_q[i] && !st_io && (PTR_W'(i) != head_q) && blk_q[i] == st_blk) begin
        mrg_hit = 1'b1;
        mrg_idx = PTR_W'(i);
      end
      if (vld_q[i] && blk_q[i] == rd_blk)
        rd_hit = 1'b1;
    end
  end

  assign st_ready = mrg_hit || !full;
  assign rd_ready = !(rd_valid && rd_hit);

  wire st_fire = st_valid && st_ready;
  wire push    = st_fire && !mrg_hit;
  wire pop     = mem_req && mem_ack;

  assign mem_req  = vld_q[head_q];
  assign mem_addr = {blk_q[head_q], {OFF_W{1'b0}}};
  assign mem_data = data_q[head_q];

  for (genvar w = 0; w < WORDS; w++) begin : g_be
    assign mem_be[w*BYTES_W +: BYTES_W] = {BYTES_W{mask_q[head_q][w]}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) vld_q[i] <= 1'b0;
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop) begin
        vld_q[head_q] <= 1'b0;
        head_q        <= head_q + 1'b1;
      end
      if (push) begin
        vld_q[tail_q]  <= 1'b1;
        io_q[tail_q]   <= st_io;
        blk_q[tail_q]  <= st_blk;
        mask_q[tail_q] <= WORDS'(1) << st_widx;
        data_q[tail_q][int'(st_widx)*WORD_W +: WORD_W] <= st_data;
        tail_q         <= tail_q + 1'b1;
      end else if (st_fire) begin
        mask_q[mrg_idx][st_widx] <= 1'b1;
        data_q[mrg_idx][int'(st_widx)*WORD_W +: WORD_W] <= st_data;
      end
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assert_empty_never_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> rd_ready);

  assert_line_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data) && $stable(mem_be)));

  assert_stall_only_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |-> full);

  assert_io_single_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && io_q[head_q]) |-> ($countones(mem_be) == BYTES_W));

  assert_req_has_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_be != '0));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ENTRIES));
endmodule

// File: tb/coalescing_store_buffer_bench.sv
module coalescing_store_buffer_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         st_valid = 1'b0;
  logic [31:0]  st_addr = '0;
  logic [31:0]  st_data = '0;
  logic         st_ready;
  logic         rd_valid = 1'b0;
  logic [31:0]  rd_addr = '0;
  logic         rd_ready;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic [255:0] mem_data;
  logic [31:0]  mem_be;
  logic         mem_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ack_allow = 1'b0;

  logic [31:0]  exp_addr [$];
  logic [31:0]  exp_be   [$];
  logic [255:0] exp_data [$];
  string        exp_tag  [$];

  always #10 clk = ~clk;

  coalescing_store_buffer u_coalescing_store_buffer (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_ready(st_ready),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .mem_ack(mem_ack)
  );

  function automatic logic [255:0] be_bits(input logic [31:0] be);
    logic [255:0] m;
    for (int b = 0; b < 32; b++) m[b*8 +: 8] = {8{be[b]}};
    return m;
  endfunction

  function automatic logic [255:0] wd(input int w, input logic [31:0] v);
    return {224'b0, v} << (w * 32);
  endfunction

  function automatic logic [31:0] wbe(input int w);
    return 32'hF << (w * 4);
  endfunction

  task automatic check(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic expect_line(input logic [31:0] a, input logic [31:0] be, input logic [255:0] d, input string tag);
    exp_addr.push_back(a);
    exp_be.push_back(be);
    exp_data.push_back(d);
    exp_tag.push_back(tag);
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_data = d;
    #1;
    while (!st_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 st_valid = 1'b0;
  endtask

  task automatic drain_all();
    ack_allow = 1'b1;
    for (int i = 0; i < 200 && exp_addr.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    ack_allow = 1'b0;
    check("R6 all expected lines written", 256'(exp_addr.size()), 256'd0);
  endtask

  // monitor: compares each acknowledged write with the scoreboard
  always @(negedge clk) begin
    if (mem_req && ack_allow) begin
      checks++;
      if (exp_addr.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected write actual=%0h expected=none", mem_addr);
      end else begin
        logic [31:0] ea, eb;
        logic [255:0] ed;
        string t;
        ea = exp_addr.pop_front(); eb = exp_be.pop_front();
        ed = exp_data.pop_front(); t = exp_tag.pop_front();
        if (mem_addr !== ea || mem_be !== eb || (mem_data & be_bits(eb)) !== (ed & be_bits(eb))) begin
          errors++;
          $display("FAIL %s actual=%0h/%0h/%0h expected=%0h/%0h/%0h", t,
                   mem_addr, mem_be, mem_data & be_bits(eb), ea, eb, ed & be_bits(eb));
        end
      end
      mem_ack <= 1'b1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 mem_req after reset", 256'(mem_req), 256'd0);
    check("R1 st_ready after reset", 256'(st_ready), 256'd1);
    check("R1 rd_ready after reset", 256'(rd_ready), 256'd1);

    // batch 1: merge, frozen head, overwrite, I/O, full
    store(32'h0000_1004, 32'hA1A1_0001);
    store(32'h0000_1008, 32'hB2B2_0002);
    store(32'h0000_100C, 32'hC3C3_0003);
    store(32'h0000_1008, 32'hD4D4_0004);
    @(negedge clk);
    check("R9 head held without ack", 256'(mem_addr), 256'h1000);
    check("R4 head line enables untouched", 256'(mem_be), 256'(wbe(1)));
    store(32'hF000_0010, 32'hE5E5_0005);
    store(32'hF000_0014, 32'hF6F6_0006);
    @(negedge clk);
    st_valid = 1'b1; st_addr = 32'h0000_2000; st_data = 32'h1;
    #1 check("R7 stall when full and no match", 256'(st_ready), 256'd0);
    st_addr = 32'hF000_0018;
    #1 check("R5 I/O store never merges when full", 256'(st_ready), 256'd0);
    st_addr = 32'h0000_1004;
    #1 check("R7 merge accepted when full", 256'(st_ready), 256'd1);
    st_valid = 1'b0;
    store(32'h0000_1004, 32'h7777_0007);
    rd_valid = 1'b1; rd_addr = 32'h0000_1010;
    #1 check("R8 read held by pending line", 256'(rd_ready), 256'd0);
    rd_addr = 32'hF000_0000;
    #1 check("R8 read held by pending I/O line", 256'(rd_ready), 256'd0);
    rd_addr = 32'h0000_3000;
    #1 check("R8 read to clean line passes", 256'(rd_ready), 256'd1);

    expect_line(32'h0000_1000, wbe(1), wd(1, 32'hA1A1_0001), "R4 head drained alone");
    expect_line(32'h0000_1000, wbe(1) | wbe(2) | wbe(3),
                wd(1, 32'h7777_0007) | wd(2, 32'hD4D4_0004) | wd(3, 32'hC3C3_0003),
                "R3 R10 merged line");
    expect_line(32'hF000_0000, wbe(4), wd(4, 32'hE5E5_0005), "R5 I/O first");
    expect_line(32'hF000_0000, wbe(5), wd(5, 32'hF6F6_0006), "R5 I/O second");
    drain_all();
    rd_addr = 32'h0000_1010;
    #1 check("R8 read released after drain", 256'(rd_ready), 256'd1);
    check("R9 idle after all acks", 256'(mem_req), 256'd0);
    rd_valid = 1'b0;

    // batch 2: ordering across lines
    store(32'h0000_3000, 32'h3000_0000);
    store(32'h0000_4000, 32'h4000_0000);
    store(32'h0000_5000, 32'h5000_0000);
    store(32'h0000_501C, 32'h5000_0007);
    store(32'h0000_4000, 32'h4000_1111);
    store(32'h0000_4010, 32'h4000_0004);
    expect_line(32'h0000_3000, wbe(0), wd(0, 32'h3000_0000), "R2 R6 first line");
    expect_line(32'h0000_4000, wbe(0) | wbe(4),
                wd(0, 32'h4000_1111) | wd(4, 32'h4000_0004), "R6 R10 second line");
    expect_line(32'h0000_5000, wbe(0) | wbe(7),
                wd(0, 32'h5000_0000) | wd(7, 32'h5000_0007), "R3 R6 third line");
    drain_all();
    @(negedge clk);
    check("R1 st_ready once empty again", 256'(st_ready), 256'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule